// File: doc/BRIEF.md
# Load-Use and Branch Squash Interlock

This block is the hazard control for a five-stage in-order pipeline with an eight-entry register file. It keeps its own shadow of the instruction that occupies the execute stage (its destination index, whether it writes a register, and whether it is a load). It compares the two source indices of the instruction now in decode against that shadow. Operand forwarding is assumed to exist elsewhere, so only a load feeding the very next instruction needs a pause. In that case the block freezes the program counter and the fetch/decode register for one cycle, and a nop goes into the decode/execute register.

Control flow follows an assume-not-taken policy. Fetch keeps going down the sequential path. When the execute stage reports that a branch was taken, the block squashes the two younger instructions: the one in fetch/decode is cleared, and the one in decode is replaced by a nop on its way to execute. It also tells fetch to load the branch target. The register file, the ALU, the caches and the forwarding multiplexers are not part of this block. They use its enables.

Top module: `pipe_interlock`

## Requirements
- R1: While reset is low and in the cycle right after it is released, the execute shadow is empty. All five outputs stay 0 whatever the decode fields are, and even when ex_br_taken is 1.
- R2: A load-use stall happens when all of these hold: the execute shadow holds a valid instruction with dec_is_load=1, dec_wr_en=1 and a destination other than 0; dec_valid is 1; and dec_src_a or dec_src_b equals that destination (3-bit equality). In that cycle pc_hold, ifid_hold and idex_bubble are 1, and ifid_squash and fetch_redirect are 0. The output vector {pc_hold, ifid_hold, idex_bubble, ifid_squash, fetch_redirect} is 11100.
- R3: A stall lasts exactly one cycle. When the decode fields are held unchanged in the following cycle, all outputs are 0.
- R4: A producer with dec_is_load=0 never causes a stall, even when its destination equals a source of the next instruction.
- R5: A destination index of 0 never causes a stall.
- R6: A load with dec_wr_en=0 never causes a stall.
- R7: While dec_valid is 0, no stall is raised, and the decode fields in that cycle do not enter the execute shadow.
- R8: When ex_br_taken is 1 and the execute shadow is valid, ifid_squash, fetch_redirect and idex_bubble are 1, and pc_hold and ifid_hold are 0. The output vector is 00111.
- R9: When ex_br_taken is 1 while the execute shadow holds a bubble, it has no effect on any output.
- R10: If a squash and a load-use stall would both occur in the same cycle, only the squash takes effect (vector 00111).
- R11: An instruction that is stalled or squashed in decode does not enter the execute shadow. As a result, a decode reader in the next cycle sees no hazard from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src_a | input | REG_W | First source register index of the decode instruction |
| dec_src_b | input | REG_W | Second source register index of the decode instruction |
| dec_dst | input | REG_W | Destination register index of the decode instruction |
| dec_wr_en | input | 1 | Decode instruction writes its destination |
| dec_is_load | input | 1 | Decode instruction is a load |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Write a nop into the decode/execute register |
| ifid_squash | output | 1 | Clear the fetch/decode register to a nop |
| fetch_redirect | output | 1 | Load the branch target into the program counter |

## Verification
The hardest case to reach is a taken branch that coincides with a pending load-use match. This is the priority case. The stimulus first places a load into the execute shadow, then presents a decode instruction that reads the load's destination and raises ex_br_taken in that same cycle. A close relative is a taken branch that arrives while execute holds the bubble left by a stall. It is reached by asserting ex_br_taken during the cycle that follows a stall. In both cases the cycle after the event checks that the squashed or stalled instruction never reached the shadow: a dependent reader is presented and must not be stalled.

// File: rtl/interlock_pkg.sv
`timescale 1ns/1ps
package interlock_pkg;
  // Arbitration outcome for one cycle; squash outranks stall.
  typedef enum logic [1:0] {
    CTL_RUN   = 2'd0,
    CTL_STALL = 2'd1,
    CTL_FLUSH = 2'd2
  } ctl_e;
endpackage

// File: rtl/ilk_src_match.sv
`timescale 1ns/1ps
module ilk_src_match #(
  parameter int RW   = 3,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][RW-1:0] src_i,
  input  logic [RW-1:0]           dst_i,
  input  logic                    dst_live_i,
  output logic                    hit_o
);
  logic [NSRC-1:0] eq;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign eq[g] = (src_i[g] == dst_i);
  end

  assign hit_o = dst_live_i && (|eq);
endmodule

// File: rtl/ilk_ex_slot.sv
`timescale 1ns/1ps
module ilk_ex_slot #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [RW-1:0] dst_i,
  input  logic          wen_i,
  input  logic          load_i,
  output logic          valid_o,
  output logic [RW-1:0] dst_o,
  output logic          load_live_o
);
  logic          valid_q, valid_d;
  logic [RW-1:0] dst_q, dst_d;
  logic          wen_q, wen_d;
  logic          load_q, load_d;

  // Next state: a bubble clears valid; fields load only on capture.
  always_comb begin
    valid_d = take_i;
    dst_d   = dst_q;
    wen_d   = wen_q;
    load_d  = load_q;
    if (take_i) begin
      dst_d  = dst_i;
      wen_d  = wen_i;
      load_d = load_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dst_q   <= '0;
      wen_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      dst_q   <= dst_d;
      wen_q   <= wen_d;
      load_q  <= load_d;
    end
  end

  assign valid_o     = valid_q;
  assign dst_o       = dst_q;
  assign load_live_o = valid_q && wen_q && load_q && (dst_q != '0);
endmodule

// File: rtl/pipe_interlock.sv
`timescale 1ns/1ps
module pipe_interlock #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] dec_dst,
  input  logic             dec_wr_en,
  input  logic             dec_is_load,
  input  logic             ex_br_taken,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             ifid_squash,
  output logic             fetch_redirect
);
  import interlock_pkg::*;

  localparam int NSRC = 2;

  logic                       ex_valid;
  logic                       ex_load_live;
  logic [REG_W-1:0]           ex_dst;
  logic                       use_hit;
  logic                       take;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  ctl_e                       mode;

  assign srcs = {dec_src_b, dec_src_a};

  ilk_src_match #(.RW(REG_W), .NSRC(NSRC)) u_match (
    .src_i      (srcs),
    .dst_i      (ex_dst),
    .dst_live_i (ex_load_live),
    .hit_o      (use_hit)
  );

  // Squash first, then load-use stall, else run.
  always_comb begin
    if (ex_br_taken && ex_valid)  mode = CTL_FLUSH;
    else if (dec_valid && use_hit) mode = CTL_STALL;
    else                           mode = CTL_RUN;
  end

  assign take = dec_valid && (mode == CTL_RUN);

  ilk_ex_slot #(.RW(REG_W)) u_ex (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .dst_i       (dec_dst),
    .wen_i       (dec_wr_en),
    .load_i      (dec_is_load),
    .valid_o     (ex_valid),
    .dst_o       (ex_dst),
    .load_live_o (ex_load_live)
  );

  assign pc_hold        = (mode == CTL_STALL);
  assign ifid_hold      = (mode == CTL_STALL);
  assign idex_bubble    = (mode != CTL_RUN);
  assign ifid_squash    = (mode == CTL_FLUSH);
  assign fetch_redirect = (mode == CTL_FLUSH);
endmodule

// File: rtl/pipe_interlock_chk.sv
`timescale 1ns/1ps
module pipe_interlock_chk #(
  parameter int REG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [REG_W-1:0] dec_dst,
  input logic             pc_hold,
  input logic             idex_bubble,
  input logic             ifid_squash,
  input logic             fetch_redirect
);
  AST_STALL_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> idex_bubble && !fetch_redirect); // R2
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |=> !pc_hold); // R3
  AST_ZERO_DST_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_dst == '0 && !pc_hold && !ifid_squash) |=> !pc_hold); // R5
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !pc_hold); // R7
  AST_SQUASH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_squash |-> fetch_redirect && idex_bubble); // R8
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_squash |-> !pc_hold); // R10
  AST_NO_STALL_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_squash |=> !pc_hold); // R11
endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dec_valid      (dec_valid),
  .dec_dst        (dec_dst),
  .pc_hold        (pc_hold),
  .idex_bubble    (idex_bubble),
  .ifid_squash    (ifid_squash),
  .fetch_redirect (fetch_redirect)
);

// File: tb/pipe_interlock_test.sv
`timescale 1ns/1ps
module pipe_interlock_test;
  localparam logic [4:0] NONE  = 5'b00000;
  localparam logic [4:0] STALL = 5'b11100;
  localparam logic [4:0] FLUSH = 5'b00111;

  typedef struct {
    logic [4:0] e;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic [2:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic       dec_wr_en = 1'b0, dec_is_load = 1'b0, ex_br_taken = 1'b0;
  logic       pc_hold, ifid_hold, idex_bubble, ifid_squash, fetch_redirect;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  pipe_interlock #(.REG_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .dec_wr_en(dec_wr_en), .dec_is_load(dec_is_load), .ex_br_taken(ex_br_taken),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_squash(ifid_squash), .fetch_redirect(fetch_redirect)
  );

  // Driver: one decode slot per cycle, expected output vector queued.
  task automatic step(input logic v, input logic [2:0] a, input logic [2:0] b,
                      input logic [2:0] d, input logic w, input logic l,
                      input logic br, input logic [4:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    dec_valid = v; dec_src_a = a; dec_src_b = b; dec_dst = d;
    dec_wr_en = w; dec_is_load = l; ex_br_taken = br;
    x.e = e; x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: samples mid low phase, compares with queue head.
  initial begin
    exp_t x;
    logic [4:0] got;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        x = q.pop_front();
        got = {pc_hold, ifid_hold, idex_bubble, ifid_squash, fetch_redirect};
        n_chk++;
        if (got !== x.e) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", x.tag, got, x.e);
        end
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    step(1, 3'd3, 3'd3, 3'd3, 1, 1, 1, NONE, "R1");          // in reset
    #6; dec_valid = 1'b0; ex_br_taken = 1'b0; rst_n = 1'b1;
    step(1, 3'd3, 3'd3, 3'd3, 1, 1, 0, NONE, "R1");          // load r3 enters
    step(1, 3'd3, 3'd0, 3'd4, 1, 0, 0, STALL, "R2");         // src_a match
    step(1, 3'd3, 3'd0, 3'd4, 1, 0, 0, NONE, "R3");          // alu r4 enters
    step(1, 3'd4, 3'd4, 3'd5, 1, 1, 0, NONE, "R4");          // load r5 enters
    step(1, 3'd1, 3'd5, 3'd2, 1, 0, 0, STALL, "R2");         // src_b match
    step(1, 3'd1, 3'd5, 3'd2, 1, 0, 0, NONE, "R3");          // alu r2 enters
    step(1, 3'd0, 3'd0, 3'd0, 1, 1, 0, NONE, "R4");          // load r0 enters
    step(1, 3'd0, 3'd0, 3'd6, 1, 1, 0, NONE, "R5");          // load r6 enters
    step(1, 3'd7, 3'd7, 3'd1, 1, 0, 0, NONE, "R2");          // no index match
    step(1, 3'd0, 3'd0, 3'd5, 0, 1, 0, NONE, "R4");          // load r5 no write
    step(1, 3'd5, 3'd5, 3'd3, 1, 1, 0, NONE, "R6");          // load r3 enters
    step(0, 3'd3, 3'd3, 3'd3, 1, 1, 0, NONE, "R7");          // invalid decode
    step(1, 3'd3, 3'd3, 3'd0, 0, 0, 0, NONE, "R7");          // shadow empty
    step(1, 3'd1, 3'd1, 3'd3, 1, 1, 0, NONE, "R6");          // load r3 enters
    step(1, 3'd3, 3'd1, 3'd2, 1, 0, 0, STALL, "R2");
    step(1, 3'd3, 3'd1, 3'd2, 1, 0, 1, NONE, "R9");          // taken on bubble
    step(1, 3'd4, 3'd4, 3'd3, 1, 1, 1, FLUSH, "R8");         // squash load r3
    step(1, 3'd3, 3'd3, 3'd4, 1, 0, 0, NONE, "R11");
    step(1, 3'd0, 3'd0, 3'd5, 1, 1, 0, NONE, "R4");          // load r5 enters
    step(1, 3'd5, 3'd0, 3'd1, 1, 0, 1, FLUSH, "R10");        // both at once
    step(1, 3'd5, 3'd5, 3'd1, 1, 0, 0, NONE, "R11");
    step(1, 3'd0, 3'd0, 3'd7, 1, 1, 0, NONE, "R4");          // load r7 enters
    step(1, 3'd7, 3'd7, 3'd7, 1, 1, 0, STALL, "R2");         // load after load
    step(1, 3'd7, 3'd7, 3'd7, 1, 1, 0, NONE, "R3");
    step(1, 3'd7, 3'd0, 3'd1, 1, 0, 0, STALL, "R2");
    step(1, 3'd7, 3'd0, 3'd1, 1, 0, 0, NONE, "R3");
    @(negedge clk);
    dec_valid = 1'b0; ex_br_taken = 1'b0;
    #8;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule